// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block turns the register operand of an 8-bit microcontroller-style core into a 12-bit data RAM address. It also holds the bank register and the RAM behind it. The data space is sixteen pages of 256 bytes.

The address is resolved in one of three ways:
- **Banked mode.** The opcode supplies an 8-bit offset and the bank register supplies the page number.
- **Access window.** An access-select bit, when low, ignores the bank register and uses a fixed split window instead. The lowest 96 bytes of page 0 sit directly below the top 160 bytes of page 15, where the special registers live.
- **Full-address mode.** A register-to-register move supplies all twelve address bits itself.

A parameter bitmask marks which pages hold storage. Any access that lands on a page without storage reads as zero and has no effect when written. The resolved address is driven out on every cycle.

A literal load sets the bank register, and only its low four bits are kept. Writes take effect on the rising clock edge. Reads are combinational from the address resolved in the same cycle.

Top module: `dmem_addr_unit`

## Requirements
- R1: With `full_mode`=0 and `use_bank`=1, `res_addr` equals `{bank_q[3:0], offset}`.
- R2: With `full_mode`=0, `use_bank`=0 and `offset` in 00h–5Fh, `res_addr` equals `{4'h0, offset}`.
- R3: With `full_mode`=0, `use_bank`=0 and `offset` in 60h–FFh, `res_addr` equals `{4'hF, offset}`. Offset 5Fh and offset 60h therefore give the adjacent window locations 05Fh and F60h.
- R4: With `full_mode`=1, `res_addr` equals `full_addr`, whatever the values of `use_bank` and the bank register.
- R5: A cycle with `bank_load`=1 makes `bank_q` equal `{4'h0, bank_lit[3:0]}` from the next cycle on. `bank_q[7:4]` always reads 0, and `bank_q` keeps its value when `bank_load`=0. A write in the load cycle still uses the old bank.
- R6: After reset, `bank_q` is 00h.
- R7: A byte written with `wr_en`=1 to an address on an implemented page is returned on `rd_data` by a later read of that address.
- R8: With `rd_en`=1 and `res_addr[11:8]` on a page whose bit in `BANK_MASK` is 0, `rd_data` is 00h.
- R9: A write to a page without storage changes no stored byte, including the byte at the same offset on any implemented page.
- R10: With `rd_en`=0, `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| offset | input | 8 | Register offset from the opcode |
| use_bank | input | 1 | 1 = page from bank register, 0 = split access window |
| full_mode | input | 1 | 1 = take the whole address from `full_addr` |
| full_addr | input | 12 | Direct address for register-to-register moves |
| bank_load | input | 1 | Load `bank_lit` into the bank register |
| bank_lit | input | 8 | Literal for the bank register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Byte to store |
| rd_data | output | DATA_W | Byte read at `res_addr` |
| res_addr | output | 12 | Resolved data address |
| bank_q | output | 8 | Bank register read value |

## Verification
The hardest case to reach is proving that a dropped write left storage untouched. A page without storage reads as zero whether or not the write landed, so reading it back shows nothing. The stimulus therefore first stores a known byte on an implemented page. It then writes a different byte at the same offset on an unimplemented page, and finally returns to the first page to confirm the byte survived. A second hard case is a bank load in the same cycle as a write. The stimulus pairs the two and then reads back under both the old page and the new one.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int OFF_W  = 8;
  localparam int PAGE_W = 4;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int PAGES  = 1 << PAGE_W;
  localparam logic [OFF_W-1:0]  WIN_SPLIT = 8'h60;
  localparam logic [PAGE_W-1:0] PAGE_TOP  = '1;

  typedef logic [ADDR_W-1:0] daddr_t;

  function automatic daddr_t win_map(input logic [OFF_W-1:0] off);
    if (off < WIN_SPLIT) return {{PAGE_W{1'b0}}, off};
    return {PAGE_TOP, off};
  endfunction

  function automatic daddr_t resolve(input logic full, input daddr_t faddr,
                                     input logic banked, input logic [OFF_W-1:0] off,
                                     input logic [PAGE_W-1:0] page);
    if (full)   return faddr;
    if (!banked) return win_map(off);
    return {page, off};
  endfunction

  function automatic logic page_present(input logic [PAGES-1:0] mask,
                                        input logic [PAGE_W-1:0] page);
    return mask[page];
  endfunction
endpackage

// File: rtl/dmem_bank_reg.sv
module dmem_bank_reg
  import dmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  lit,
  output logic [7:0]  bank_q
);
  logic [7:0] bank_d;
  // upper nibble is forced to zero on every load
  assign bank_d = {lit[7:PAGE_W] & {(8-PAGE_W){1'b0}}, lit[PAGE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= bank_d;
  end
endmodule

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_pkg::*;
#(
  parameter logic [15:0] BANK_MASK = 16'h800F
) (
  input  logic              full_mode,
  input  daddr_t            full_addr,
  input  logic              use_bank,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PAGE_W-1:0] page,
  output daddr_t            addr,
  output logic              hit
);
  assign addr = resolve(full_mode, full_addr, use_bank, offset, page);
  assign hit  = page_present(BANK_MASK, addr[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/dmem_paged_ram.sv
module dmem_paged_ram
  import dmem_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BANK_MASK = 16'h800F
) (
  input  logic              clk,
  input  daddr_t            addr,
  input  logic              hit,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << OFF_W;
  logic [DATA_W-1:0] page_rd [PAGES];
  logic [PAGE_W-1:0] sel;
  logic [OFF_W-1:0]  loc;
  assign sel = addr[ADDR_W-1:OFF_W];
  assign loc = addr[OFF_W-1:0];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    if (BANK_MASK[p]) begin : g_store
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en && (sel == p[PAGE_W-1:0])) mem[loc] <= wr_data;
      end
      assign page_rd[p] = mem[loc];
    end else begin : g_empty
      assign page_rd[p] = '0;
    end
  end

  assign rd_data = (rd_en && hit) ? page_rd[sel] : '0;
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
  import dmem_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BANK_MASK = 16'h800F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        offset,
  input  logic              use_bank,
  input  logic              full_mode,
  input  logic [11:0]       full_addr,
  input  logic              bank_load,
  input  logic [7:0]        bank_lit,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [11:0]       res_addr,
  output logic [7:0]        bank_q
);
  logic   bank_hit;
  daddr_t addr_w;

  dmem_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .lit(bank_lit), .bank_q(bank_q)
  );

  dmem_addr_resolve #(.BANK_MASK(BANK_MASK)) u_res (
    .full_mode(full_mode), .full_addr(full_addr), .use_bank(use_bank),
    .offset(offset), .page(bank_q[PAGE_W-1:0]), .addr(addr_w), .hit(bank_hit)
  );

  dmem_paged_ram #(.DATA_W(DATA_W), .BANK_MASK(BANK_MASK)) u_ram (
    .clk(clk), .addr(addr_w), .hit(bank_hit), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  assign res_addr = addr_w;
endmodule

// File: rtl/dmem_addr_unit_chk.sv
module dmem_addr_unit_chk #(
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BANK_MASK = 16'h800F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        offset,
  input logic              use_bank,
  input logic              full_mode,
  input logic [11:0]       full_addr,
  input logic              bank_load,
  input logic [7:0]        bank_lit,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [11:0]       res_addr,
  input logic [7:0]        bank_q
);
  assert_banked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && use_bank) |-> (res_addr[11:8] == bank_q[3:0] && res_addr[7:0] == offset));

  assert_win_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !use_bank && offset < 8'd96) |-> res_addr[11:8] == 4'h0);

  assert_win_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !use_bank && offset >= 8'd96) |-> res_addr[11:8] == 4'hF);

  assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> res_addr == full_addr);

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> bank_q == {4'h0, $past(bank_lit[3:0])});

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_q));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q[7:4] == 4'h0);

  assert_absent_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !BANK_MASK[res_addr[11:8]]) |-> rd_data == '0);

  assert_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

bind dmem_addr_unit dmem_addr_unit_chk #(.DATA_W(DATA_W), .BANK_MASK(BANK_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .offset(offset), .use_bank(use_bank),
  .full_mode(full_mode), .full_addr(full_addr), .bank_load(bank_load),
  .bank_lit(bank_lit), .rd_en(rd_en), .rd_data(rd_data), .res_addr(res_addr),
  .bank_q(bank_q)
);

// File: tb/dmem_addr_unit_bench.sv
`timescale 1ns/1ps
module dmem_addr_unit_bench;
  localparam logic [15:0] MASK = 16'h800F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  offset = 0;
  logic        use_bank = 1;
  logic        full_mode = 0;
  logic [11:0] full_addr = 0;
  logic        bank_load = 0;
  logic [7:0]  bank_lit = 0;
  logic        rd_en = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic [11:0] res_addr;
  logic [7:0]  bank_q;

  always #2.5 clk = ~clk;

  dmem_addr_unit #(.DATA_W(8), .BANK_MASK(MASK)) u_dmem_addr_unit (
    .clk(clk), .rst_n(rst_n), .offset(offset), .use_bank(use_bank),
    .full_mode(full_mode), .full_addr(full_addr), .bank_load(bank_load),
    .bank_lit(bank_lit), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .res_addr(res_addr), .bank_q(bank_q)
  );

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  data;
    logic [7:0]  bank;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [4096];
  logic [3:0]  m_bank = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push what the ports must show
  task automatic op(input bit full, input logic [11:0] fa, input bit bnk,
                    input logic [7:0] off, input bit ld, input logic [7:0] lit,
                    input bit rd, input bit wr, input logic [7:0] wd, input string tag);
    exp_t e;
    int a;
    @(negedge clk);
    full_mode = full; full_addr = fa; use_bank = bnk; offset = off;
    bank_load = ld; bank_lit = lit; rd_en = rd; wr_en = wr; wr_data = wd;
    if (full)      a = fa;
    else if (!bnk) a = (off >= 96) ? 32'hF00 + off : off;
    else           a = m_bank * 256 + off;
    e.addr = a[11:0];
    e.data = (rd && MASK[a / 256]) ? model[a] : 8'h00;
    e.bank = {4'h0, m_bank};
    e.tag  = tag;
    sb.push_back(e);
    if (wr && MASK[a / 256]) model[a] = wd;
    if (ld) m_bank = lit[3:0];
  endtask

  // monitor: compare ports late in the low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "res_addr", res_addr, e.addr);
        check(e.tag, "rd_data", rd_data, e.data);
        check(e.tag, "bank_q", bank_q, e.bank);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    // zero all implemented storage so reads are defined
    repeat (2) @(negedge clk);
    rst_n = 1;
    op(0, 0, 1, 8'h00, 0, 0, 1, 0, 0, "R6");
    for (int p = 0; p < 16; p++) begin
      if (MASK[p]) begin
        op(0, 0, 1, 8'h00, 1, p[7:0], 0, 0, 0, "R5");
        for (int o = 0; o < 256; o++) op(0, 0, 1, o[7:0], 0, 0, 0, 1, 8'h00, "R7");
      end
    end
    op(0, 0, 1, 8'h00, 1, 8'h00, 0, 0, 0, "R5");
    // split window edges
    op(0, 0, 0, 8'h10, 0, 0, 0, 1, 8'hA5, "R2");
    op(0, 0, 0, 8'h10, 0, 0, 1, 0, 0,     "R7");
    op(0, 0, 0, 8'h5F, 0, 0, 0, 1, 8'h5A, "R2");
    op(0, 0, 0, 8'h60, 0, 0, 0, 1, 8'h61, "R3");
    op(0, 0, 0, 8'h5F, 0, 0, 1, 0, 0,     "R2");
    op(0, 0, 0, 8'h60, 0, 0, 1, 0, 0,     "R3");
    op(0, 0, 0, 8'hFF, 0, 0, 1, 1, 8'hEE, "R3");
    op(0, 0, 0, 8'hFF, 0, 0, 1, 0, 0,     "R3");
    // banked access, load ignores upper nibble
    op(0, 0, 1, 8'h20, 1, 8'h03, 0, 0, 0, "R5");
    op(0, 0, 1, 8'h20, 0, 0, 0, 1, 8'h3C, "R1");
    op(0, 0, 1, 8'h20, 0, 0, 1, 0, 0,     "R7");
    op(0, 0, 1, 8'h60, 1, 8'hF2, 1, 0, 0, "R5");
    op(0, 0, 1, 8'h60, 0, 0, 1, 0, 0,     "R5");
    // full-address mode ignores bank register and access bit
    op(1, 12'h123, 0, 8'h00, 0, 0, 0, 1, 8'h77, "R4");
    op(1, 12'h123, 1, 8'hFF, 0, 0, 1, 0, 0,     "R4");
    op(0, 0, 1, 8'h23, 1, 8'h01, 0, 0, 0, "R5");
    op(0, 0, 1, 8'h23, 0, 0, 1, 0, 0,     "R4");
    // unimplemented page: reads zero, write leaves storage alone
    op(0, 0, 1, 8'h20, 1, 8'h05, 0, 0, 0, "R5");
    op(0, 0, 1, 8'h20, 0, 0, 0, 1, 8'h99, "R9");
    op(0, 0, 1, 8'h20, 0, 0, 1, 0, 0,     "R8");
    op(1, 12'h720, 0, 8'h00, 0, 0, 1, 1, 8'h44, "R8");
    op(0, 0, 1, 8'h20, 1, 8'h03, 0, 0, 0, "R5");
    op(0, 0, 1, 8'h20, 0, 0, 1, 0, 0,     "R9");
    op(1, 12'h020, 0, 8'h00, 0, 0, 1, 0, 0, "R9");
    // no read strobe
    op(0, 0, 1, 8'h20, 0, 0, 0, 0, 0, "R10");
    // load and write in one cycle: write uses old page
    op(0, 0, 1, 8'h40, 1, 8'h02, 0, 1, 8'hC3, "R5");
    op(0, 0, 1, 8'h40, 1, 8'h03, 1, 0, 0,     "R5");
    op(0, 0, 1, 8'h40, 0, 0, 1, 0, 0,         "R7");
    // sweep of window offsets with distinct data
    for (int k = 0; k < 16; k++) op(0, 0, 0, k[7:0] * 8'd17, 0, 0, 0, 1, 8'h80 ^ k[7:0], "R3");
    for (int k = 0; k < 16; k++) op(0, 0, 0, k[7:0] * 8'd17, 0, 0, 1, 0, 0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule